// File: doc/BRIEF.md
# Timer Interrupt Router

This block turns the expiry events of a bank of hardware timers into interrupts. Each timer has its own configuration word and 64-bit message register. When a timer fires, its configuration selects one of three deliveries: a one-cycle pulse on an interrupt pin, a level held on a pin until it is cleared, or a message-write request whose address and data come from the message register. Pins are numbered 0 to 31. Pin 0 stands for "not connected". Arbitration between timers that share a pin is left to the interrupt controller. This block ORs the per-timer pin requests together.

Each timer keeps a status bit for level interrupts. Software clears that bit with a write-one-to-clear strobe. The block also clears it by itself when a configuration write would otherwise leave the level stuck asserted. A configuration write is sanitised before it is stored. Read-only and reserved bits are kept or zeroed. A routing pin outside the pins that the interrupt controller accepts is replaced by 0. The set of accepted pins is derived from the controller's pin count, which is a parameter.

Configuration word layout (16 bits): bit 1 trigger type (0 edge, 1 level), bit 2 interrupt enable, bits 13:9 routing pin, bit 14 message enable, bit 15 message capability (read-only, set per timer by a parameter). All other bits read as 0. Every input is sampled on the rising clock edge. Every result is visible after that same edge. A fire is judged against the configuration held before the edge.

Top module: `tirq_router`

## Requirements
- R1: After reset every status bit, pin output and message request is 0, each message register is 0, and each configuration word reads back as only its capability bit 15.
- R2: A fire on a timer whose enable bit 2 is 0 produces no pulse, no level, no message request and no status change.
- R3: A fire on a timer whose status bit is already 1 is ignored: no pulse, no message request, status and level unchanged.
- R4: When both bits 15 and 14 are 1, an enabled fire raises msg_req for exactly one cycle, with the address being the upper 32 bits and the data the lower 32 bits of that timer's message register, and drives no pin.
- R5: With message delivery inactive, the routing pin is bits 13:9. A timer routed to pin 0, or whose effective pin is 0 because message delivery is active, produces no pin output and sets no status bit. Bit 14 without bit 15 leaves pin delivery in use.
- R6: An enabled fire in edge mode (bit 1 = 0) on pin p drives bit p of pin_pulse_o for exactly one cycle and leaves the status bit at 0.
- R7: An enabled fire in level mode (bit 1 = 1) on pin p sets the status bit and holds bit p of pin_level_o until the status bit clears.
- R8: A configuration write whose effective pin is non-zero and not in the accepted set stores routing field 0. Writes to bit 15 and to reserved bits have no effect.
- R9: A configuration write clears a set status bit, and drops its level, when the new word disables the interrupt, activates message delivery, selects edge mode, or routes to a pin other than the one that was latched. Rewriting an unchanged word keeps the status bit.
- R10: A 1 in sts_clr_i clears that status bit and deasserts the pin that was latched when the level was raised. A 1 on a clear bit, and a 0 on a set bit, have no effect.
- R11: The accepted pins are 24 to 31 for a pin count of 32 or more, the top four pins below the count for a count of 20 to 31, and none below 20 (default count 24: pins 20 to 23).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fire_i | input | NUM_TIMERS | One-cycle expiry event per timer |
| sts_clr_i | input | NUM_TIMERS | Write-one-to-clear strobe for status bits |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Timer selected by the configuration write |
| cfg_data_i | input | 16 | Configuration word to write |
| msg_wr_i | input | 1 | Message register write strobe |
| msg_idx_i | input | IDX_W | Timer selected by the message write |
| msg_data_i | input | 64 | Message register value (address high, data low) |
| pin_pulse_o | output | 32 | One-cycle edge interrupts, one bit per pin |
| pin_level_o | output | 32 | Held level interrupts, one bit per pin |
| msg_req_o | output | NUM_TIMERS | One-cycle message-write request per timer |
| msg_addr_o | output | NUM_TIMERS*32 | Per-timer message address |
| msg_data_o | output | NUM_TIMERS*32 | Per-timer message data |
| status_o | output | NUM_TIMERS | Level interrupt status bits |
| cfg_o | output | NUM_TIMERS*16 | Stored configuration words |

## Verification
Most internal errors show up in the cycle right after the edge that caused them. A status bit that is set or cleared wrongly appears at once on status_o and pin_level_o. A fire that is routed wrongly appears as a pulse on the wrong pin or as a missing or extra msg_req. Routing sanitisation is visible on cfg_o right after the write. A latched pin that is stale stays hidden while the level is held. It shows only when a clear or a configuration write drops the level, so the bench checks every port after every cycle and mixes fires, clears and reconfigurations in random order.

// File: rtl/tirq_pkg.sv
// Shared definitions for the timer interrupt router: configuration word
// layout, pin geometry and helpers. Assumes 32 interrupt pins (5-bit index).
package tirq_pkg;
    localparam int CFG_W   = 16;
    localparam int ROUTE_W = 5;
    localparam int NPINS   = 1 << ROUTE_W;
    localparam int MSG_W   = 64;

    // Writable bits: type(1), enable(2), route(13:9), message enable(14)
    localparam logic [CFG_W-1:0] CFG_WR_MASK = 16'h7E06;

    typedef struct packed {
        logic               msg_cap;   // 15, read-only
        logic               msg_en;    // 14
        logic [ROUTE_W-1:0] route;     // 13:9
        logic [5:0]         rsvd_hi;   // 8:3
        logic               en;        // 2
        logic               level;     // 1
        logic               rsvd_lo;   // 0
    } cfg_t;

    // Accepted pins as a function of the controller's pin count
    function automatic logic [NPINS-1:0] accepted_pins(input int pin_count);
        if (pin_count >= 32)
            return 32'hFF00_0000;
        else if (pin_count >= 20)
            return 32'h0000_000F << (pin_count - 4);
        else
            return '0;
    endfunction

    // Message delivery is active only with both capability and enable
    function automatic logic msg_active(input cfg_t c);
        return c.msg_cap & c.msg_en;
    endfunction

    // Pin actually used for delivery; 0 when message delivery is active
    function automatic logic [ROUTE_W-1:0] eff_pin(input cfg_t c);
        return msg_active(c) ? '0 : c.route;
    endfunction
endpackage

// File: rtl/tirq_cfg_filter.sv
// Sanitises a raw configuration word before it is stored: keeps only the
// writable bits, inserts the fixed capability bit and forces an unaccepted
// routing pin to 0. Purely combinational.
module tirq_cfg_filter
    import tirq_pkg::*;
#(
    parameter logic [NPINS-1:0] ALLOWED = '0,
    parameter bit               CAP     = 1'b0
) (
    input  logic [CFG_W-1:0] raw_i,
    output cfg_t             clean_o
);
    // Mask, insert capability, validate route against the accepted set
    always_comb begin
        cfg_t t;
        t         = cfg_t'(raw_i & CFG_WR_MASK);
        t.msg_cap = CAP;
        if (eff_pin(t) != '0 && !ALLOWED[eff_pin(t)])
            t.route = '0;
        clean_o = t;
    end
endmodule

// File: rtl/tirq_chan.sv
// One timer's interrupt logic: configuration and message registers, the
// level status bit with its latched pin, and the one-cycle pulse and
// message request outputs. A fire is judged against the stored
// configuration; a same-cycle configuration write applies afterwards.
module tirq_chan
    import tirq_pkg::*;
#(
    parameter logic [NPINS-1:0] ALLOWED = '0,
    parameter bit               CAP     = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_i,
    input  logic               clr_i,
    input  logic               cfg_wr_i,
    input  logic [CFG_W-1:0]   cfg_data_i,
    input  logic               msg_wr_i,
    input  logic [MSG_W-1:0]   msg_data_i,
    output logic [CFG_W-1:0]   cfg_o,
    output logic [MSG_W-1:0]   msg_o,
    output logic               sts_o,
    output logic [ROUTE_W-1:0] lvl_pin_o,
    output logic               pulse_o,
    output logic [ROUTE_W-1:0] pulse_pin_o,
    output logic               msg_req_o
);
    cfg_t               cfg_q, cfg_new;
    logic [MSG_W-1:0]   msg_q;
    logic               sts_q, sts_mid, sts_d;
    logic [ROUTE_W-1:0] lp_q, lp_mid;
    logic               pulse_q, mreq_q;
    logic [ROUTE_W-1:0] ppin_q;
    logic               accept, pin_route, set_lvl, do_pulse, do_msg, cfg_kill;
    logic [ROUTE_W-1:0] pin_now;

    tirq_cfg_filter #(.ALLOWED(ALLOWED), .CAP(CAP)) u_filter (
        .raw_i   (cfg_data_i),
        .clean_o (cfg_new)
    );

    // Decide what this cycle's fire delivers under the stored configuration
    always_comb begin
        pin_now   = eff_pin(cfg_q);
        accept    = fire_i & cfg_q.en & ~sts_q;
        pin_route = accept & ~msg_active(cfg_q) & (pin_now != '0);
        set_lvl   = pin_route & cfg_q.level;
        do_pulse  = pin_route & ~cfg_q.level;
        do_msg    = accept & msg_active(cfg_q);
    end

    // Next status: software clear, level set, then configuration auto-clear
    always_comb begin
        sts_mid  = (sts_q & ~clr_i) | set_lvl;
        lp_mid   = set_lvl ? pin_now : lp_q;
        cfg_kill = cfg_wr_i & (~cfg_new.en | msg_active(cfg_new) |
                               ~cfg_new.level | (eff_pin(cfg_new) != lp_mid));
        sts_d    = sts_mid & ~cfg_kill;
    end

    // Register state and one-cycle outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '{msg_cap: CAP, default: '0};
            msg_q   <= '0;
            sts_q   <= 1'b0;
            lp_q    <= '0;
            pulse_q <= 1'b0;
            ppin_q  <= '0;
            mreq_q  <= 1'b0;
        end else begin
            if (cfg_wr_i) cfg_q <= cfg_new;
            if (msg_wr_i) msg_q <= msg_data_i;
            sts_q   <= sts_d;
            lp_q    <= lp_mid;
            pulse_q <= do_pulse;
            ppin_q  <= pin_now;
            mreq_q  <= do_msg;
        end
    end

    assign cfg_o       = cfg_q;
    assign msg_o       = msg_q;
    assign sts_o       = sts_q;
    assign lvl_pin_o   = lp_q;
    assign pulse_o     = pulse_q;
    assign pulse_pin_o = ppin_q;
    assign msg_req_o   = mreq_q;
endmodule

// File: rtl/tirq_pin_merge.sv
// Merges per-timer pin requests into per-pin vectors by OR. Assumes a
// request never names pin 0 (channels suppress unrouted deliveries).
module tirq_pin_merge
    import tirq_pkg::*;
#(
    parameter int NUM = 8
) (
    input  logic [NUM-1:0]         lvl_on_i,
    input  logic [NUM*ROUTE_W-1:0] lvl_pin_i,
    input  logic [NUM-1:0]         pulse_on_i,
    input  logic [NUM*ROUTE_W-1:0] pulse_pin_i,
    output logic [NPINS-1:0]       level_o,
    output logic [NPINS-1:0]       pulse_o
);
    // Decode each active request to its pin bit and accumulate
    always_comb begin
        level_o = '0;
        pulse_o = '0;
        for (int t = 0; t < NUM; t++) begin
            if (lvl_on_i[t])
                level_o[lvl_pin_i[t*ROUTE_W +: ROUTE_W]] = 1'b1;
            if (pulse_on_i[t])
                pulse_o[pulse_pin_i[t*ROUTE_W +: ROUTE_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/tirq_router.sv
// Timer interrupt router: one channel per timer, a shared write decode and
// a pin merge. Assumes write indices beyond NUM_TIMERS-1 select nothing.
module tirq_router
    import tirq_pkg::*;
#(
    parameter int                    NUM_TIMERS = 8,
    parameter int                    PIN_COUNT  = 24,
    parameter logic [NUM_TIMERS-1:0] MSG_CAP    = NUM_TIMERS'(15),
    localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_TIMERS-1:0]    fire_i,
    input  logic [NUM_TIMERS-1:0]    sts_clr_i,
    input  logic                     cfg_wr_i,
    input  logic [IDX_W-1:0]         cfg_idx_i,
    input  logic [15:0]              cfg_data_i,
    input  logic                     msg_wr_i,
    input  logic [IDX_W-1:0]         msg_idx_i,
    input  logic [63:0]              msg_data_i,
    output logic [31:0]              pin_pulse_o,
    output logic [31:0]              pin_level_o,
    output logic [NUM_TIMERS-1:0]    msg_req_o,
    output logic [NUM_TIMERS*32-1:0] msg_addr_o,
    output logic [NUM_TIMERS*32-1:0] msg_data_o,
    output logic [NUM_TIMERS-1:0]    status_o,
    output logic [NUM_TIMERS*16-1:0] cfg_o
);
    localparam logic [NPINS-1:0] ALLOWED = accepted_pins(PIN_COUNT);

    logic [NUM_TIMERS-1:0]         pulse_on;
    logic [NUM_TIMERS*ROUTE_W-1:0] lvl_pin, pulse_pin;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_chan
        logic [MSG_W-1:0] msg_w;

        tirq_chan #(.ALLOWED(ALLOWED), .CAP(MSG_CAP[t])) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .fire_i      (fire_i[t]),
            .clr_i       (sts_clr_i[t]),
            .cfg_wr_i    (cfg_wr_i && cfg_idx_i == IDX_W'(t)),
            .cfg_data_i  (cfg_data_i),
            .msg_wr_i    (msg_wr_i && msg_idx_i == IDX_W'(t)),
            .msg_data_i  (msg_data_i),
            .cfg_o       (cfg_o[t*CFG_W +: CFG_W]),
            .msg_o       (msg_w),
            .sts_o       (status_o[t]),
            .lvl_pin_o   (lvl_pin[t*ROUTE_W +: ROUTE_W]),
            .pulse_o     (pulse_on[t]),
            .pulse_pin_o (pulse_pin[t*ROUTE_W +: ROUTE_W]),
            .msg_req_o   (msg_req_o[t])
        );

        assign msg_addr_o[t*32 +: 32] = msg_w[63:32];
        assign msg_data_o[t*32 +: 32] = msg_w[31:0];
    end

    tirq_pin_merge #(.NUM(NUM_TIMERS)) u_merge (
        .lvl_on_i    (status_o),
        .lvl_pin_i   (lvl_pin),
        .pulse_on_i  (pulse_on),
        .pulse_pin_i (pulse_pin),
        .level_o     (pin_level_o),
        .pulse_o     (pin_pulse_o)
    );
endmodule

// File: rtl/tirq_router_chk.sv
// Port-level assertions for tirq_router, attached by bind.
module tirq_router_chk
    import tirq_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int PIN_COUNT  = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_TIMERS-1:0]    fire_i,
    input logic [NUM_TIMERS-1:0]    sts_clr_i,
    input logic [31:0]              pin_pulse_o,
    input logic [31:0]              pin_level_o,
    input logic [NUM_TIMERS-1:0]    msg_req_o,
    input logic [NUM_TIMERS-1:0]    status_o,
    input logic [NUM_TIMERS*16-1:0] cfg_o
);
    localparam logic [31:0] OK_PINS = accepted_pins(PIN_COUNT);

    assert_pulse_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pulse_o != '0) |-> ($past(fire_i) != '0));

    assert_msg_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req_o & ~$past(fire_i)) == '0);

    assert_status_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~$past(status_o)) & ~$past(fire_i)) == '0);

    assert_sw_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & $past(sts_clr_i & status_o)) == '0);

    assert_pins_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_level_o | pin_pulse_o) & ~OK_PINS) == '0);

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == '0) |-> (pin_level_o == '0));

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_t
        assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_i[t] && !cfg_o[t*16+2]) |=> (!msg_req_o[t] && !$rose(status_o[t])));
        assert_busy_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (fire_i[t] && status_o[t]) |=> !msg_req_o[t]);
    end
endmodule

bind tirq_router tirq_router_chk #(.NUM_TIMERS(NUM_TIMERS), .PIN_COUNT(PIN_COUNT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_i      (fire_i),
    .sts_clr_i   (sts_clr_i),
    .pin_pulse_o (pin_pulse_o),
    .pin_level_o (pin_level_o),
    .msg_req_o   (msg_req_o),
    .status_o    (status_o),
    .cfg_o       (cfg_o)
);

// File: tb/tirq_router_tb_top.sv
`timescale 1ns/1ps
// Bench for tirq_router: directed corner cases then seeded random traffic,
// every port compared each cycle against a behavioural model.
module tirq_router_tb_top;
    localparam int NT = 8;
    localparam int PC = 24;
    localparam logic [7:0] CAP = 8'h0F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] fire = '0, clr = '0;
    logic          cwr = 1'b0, mwr = 1'b0;
    logic [2:0]    cidx = '0, midx = '0;
    logic [15:0]   cdat = '0;
    logic [63:0]   mdat = '0;
    logic [31:0]   pin_pulse, pin_level;
    logic [NT-1:0] msg_req, status;
    logic [NT*32-1:0] maddr, mdata;
    logic [NT*16-1:0] cfg;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tirq_router #(.NUM_TIMERS(NT), .PIN_COUNT(PC), .MSG_CAP(CAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .sts_clr_i(clr),
        .cfg_wr_i(cwr), .cfg_idx_i(cidx), .cfg_data_i(cdat),
        .msg_wr_i(mwr), .msg_idx_i(midx), .msg_data_i(mdat),
        .pin_pulse_o(pin_pulse), .pin_level_o(pin_level), .msg_req_o(msg_req),
        .msg_addr_o(maddr), .msg_data_o(mdata), .status_o(status), .cfg_o(cfg)
    );

    // Model state
    logic [15:0] m_cfg [NT];
    logic [63:0] m_msg [NT];
    logic        m_sts [NT];
    logic [4:0]  m_lp  [NT];
    logic [31:0] e_pulse;
    logic [NT-1:0] e_mreq;

    function automatic bit pin_ok(input int p);
        if (PC >= 32) return p >= 24;
        if (PC >= 20) return (p >= PC - 4) && (p < PC);
        return 1'b0;
    endfunction

    function automatic logic [15:0] clean(input logic [15:0] d, input logic cap);
        logic [15:0] r;
        int p;
        r = d & 16'h7E06;
        r[15] = cap;
        p = (cap && d[14]) ? 0 : int'(d[13:9]);
        if (p != 0 && !pin_ok(p)) r[13:9] = '0;
        return r;
    endfunction

    function automatic logic [15:0] mk(input bit en, input bit lvl, input int route, input bit msgen);
        return 16'((int'(msgen) << 14) | (route << 9) | (int'(en) << 2) | (int'(lvl) << 1));
    endfunction

    task automatic chk(input string req, input string what, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        logic [31:0] lv;
        logic [NT*16-1:0] cf;
        logic [NT*32-1:0] ea, ed;
        logic [NT-1:0] st;
        lv = '0;
        for (int n = 0; n < NT; n++) begin
            if (m_sts[n]) lv[m_lp[n]] = 1'b1;
            cf[n*16 +: 16] = m_cfg[n];
            ea[n*32 +: 32] = m_msg[n][63:32];
            ed[n*32 +: 32] = m_msg[n][31:0];
            st[n] = m_sts[n];
        end
        chk(req, "status",    256'(status),    256'(st));
        chk(req, "pin_level", 256'(pin_level), 256'(lv));
        chk(req, "pin_pulse", 256'(pin_pulse), 256'(e_pulse));
        chk(req, "msg_req",   256'(msg_req),   256'(e_mreq));
        chk(req, "cfg",       256'(cfg),       256'(cf));
        chk(req, "msg_addr",  256'(maddr),     256'(ea));
        chk(req, "msg_data",  256'(mdata),     256'(ed));
    endtask

    // One clock: drive inputs, advance the model, compare after the edge
    task automatic step(input logic [NT-1:0] f, input logic [NT-1:0] c,
                        input logic w, input logic [2:0] wi, input logic [15:0] wd,
                        input logic mw, input logic [2:0] mi, input logic [63:0] md,
                        input string req);
        @(negedge clk);
        fire = f; clr = c; cwr = w; cidx = wi; cdat = wd;
        mwr = mw; midx = mi; mdat = md;
        e_pulse = '0; e_mreq = '0;
        for (int n = 0; n < NT; n++) begin
            logic [15:0] cc, nc;
            logic ma, acc, setl, s, nma;
            logic [4:0] pin, lp, npin;
            cc = m_cfg[n];
            ma = cc[15] & cc[14];
            pin = ma ? 5'd0 : cc[13:9];
            acc = f[n] & cc[2] & ~m_sts[n];
            setl = 1'b0;
            if (acc) begin
                if (ma) e_mreq[n] = 1'b1;
                else if (pin != 0) begin
                    if (cc[1]) setl = 1'b1;
                    else e_pulse[pin] = 1'b1;
                end
            end
            s = (m_sts[n] & ~c[n]) | setl;
            lp = setl ? pin : m_lp[n];
            if (w && wi == 3'(n)) begin
                nc = clean(wd, CAP[n]);
                nma = nc[15] & nc[14];
                npin = nma ? 5'd0 : nc[13:9];
                if (s && (!nc[2] || nma || !nc[1] || npin != lp)) s = 1'b0;
                m_cfg[n] = nc;
            end
            if (mw && mi == 3'(n)) m_msg[n] = md;
            m_sts[n] = s;
            m_lp[n] = lp;
        end
        @(posedge clk);
        #2;
        compare(req);
    endtask

    task automatic idle(input string req);
        step('0, '0, 1'b0, '0, '0, 1'b0, '0, '0, req);
    endtask

    task automatic wcfg(input int t, input logic [15:0] d, input string req);
        step('0, '0, 1'b1, 3'(t), d, 1'b0, '0, '0, req);
    endtask

    task automatic fire1(input int t, input string req);
        step(NT'(1) << t, '0, 1'b0, '0, '0, 1'b0, '0, '0, req);
    endtask

    task automatic clr1(input int t, input string req);
        step('0, NT'(1) << t, 1'b0, '0, '0, 1'b0, '0, '0, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int n = 0; n < NT; n++) begin
            m_cfg[n] = 16'(CAP[n]) << 15;
            m_msg[n] = '0; m_sts[n] = 1'b0; m_lp[n] = '0;
        end
        e_pulse = '0; e_mreq = '0;
        repeat (3) @(posedge clk);
        #2 compare("R1 during reset");
        @(negedge clk) rst_n = 1'b1;
        idle("R1 after reset");

        // R12-like read-only/reserved and R8 route validation
        wcfg(5, 16'hFFFF, "R8 all-ones on non-capable timer");
        wcfg(0, 16'hFFFF, "R8 all-ones on capable timer");
        wcfg(1, mk(1, 1, 22, 0), "R8 accepted route kept");
        wcfg(1, mk(1, 1, 5, 0), "R8 unaccepted route forced to 0");
        for (int p = 0; p < 32; p++) wcfg(6, mk(1, 0, p, 0), "R11 accepted set");

        // R7 level, R3 busy, R10 clears
        wcfg(1, mk(1, 1, 22, 0), "R7 setup");
        fire1(1, "R7 level raised");
        idle("R7 level held");
        idle("R7 level held 2");
        fire1(1, "R3 fire while set ignored");
        step('0, NT'(8'h02), 1'b0, '0, '0, 1'b0, '0, '0, "R10 sw clear");
        clr1(1, "R10 clear on zero bit");
        fire1(1, "R10 raise again");
        step('0, NT'(8'hFD), 1'b0, '0, '0, 1'b0, '0, '0, "R10 zero strobe keeps set");
        clr1(1, "R10 clear");

        // R6 edge
        wcfg(2, mk(1, 0, 21, 0), "R6 setup");
        fire1(2, "R6 edge pulse");
        idle("R6 pulse one cycle");

        // R2 disabled
        wcfg(3, mk(0, 1, 20, 0), "R2 setup");
        fire1(3, "R2 disabled fire");
        wcfg(3, mk(0, 0, 20, 0), "R2 setup edge");
        fire1(3, "R2 disabled edge fire");

        // R4 message delivery
        step('0, '0, 1'b0, '0, '0, 1'b1, 3'd0, 64'hA5A5_0001_1234_5678, "R4 message register");
        wcfg(0, mk(1, 0, 20, 1), "R4 setup");
        fire1(0, "R4 message request");
        idle("R4 request one cycle");
        wcfg(0, mk(1, 1, 20, 1), "R4 level setup");
        fire1(0, "R4 level type still message");

        // R5 pin 0 and message enable without capability
        wcfg(5, mk(1, 0, 23, 1), "R5 setup no capability");
        fire1(5, "R5 pin delivery without capability");
        wcfg(5, mk(1, 1, 0, 0), "R5 route 0 setup");
        fire1(5, "R5 route 0 silent");

        // R9 configuration auto-clear cases
        wcfg(1, mk(1, 1, 22, 0), "R9 setup");
        fire1(1, "R9 raise");
        wcfg(1, mk(1, 1, 22, 0), "R9 unchanged keeps");
        wcfg(1, mk(0, 1, 22, 0), "R9 disable clears");
        wcfg(1, mk(1, 1, 22, 0), "R9 re-setup");
        fire1(1, "R9 raise");
        wcfg(1, mk(1, 0, 22, 0), "R9 edge clears");
        wcfg(1, mk(1, 1, 22, 0), "R9 re-setup");
        fire1(1, "R9 raise");
        wcfg(1, mk(1, 1, 23, 0), "R9 route change clears");
        wcfg(2, mk(1, 1, 20, 0), "R9 setup msg");
        fire1(2, "R9 raise");
        wcfg(2, mk(1, 1, 20, 1), "R9 message clears");

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] d;
            int sel;
            d = 16'($urandom);
            d[2] = ($urandom % 4) != 0;
            sel = $urandom % 4;
            if (sel == 0) d[13:9] = '0;
            else if (sel == 1) d[13:9] = 5'(20 + $urandom % 4);
            else if (sel == 3) d[13:9] = 5'd22;
            step(NT'($urandom & $urandom & $urandom),
                 (($urandom % 6) == 0) ? NT'($urandom) : '0,
                 ($urandom % 4) == 0, 3'($urandom), d,
                 ($urandom % 8) == 0, 3'($urandom), {$urandom, $urandom},
                 "random R1-R11 mix");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule